// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Enable Generator

This block turns the system clock into the single-cycle enables that pace a serial transmitter and receiver. A first stage divides the clock by a factor from 1 to 16 in steps of one half. A second stage, an 11-bit reloading down-counter, divides the result again to give an enable at sixteen times the bit rate. A final divide-by-16 stage per direction gives the bit-rate enable. Nothing here is a derived clock: every output is a one-cycle enable in the system clock domain.

Software programs the block through two 8-bit registers. One holds the low eight divisor bits. The other holds the 5-bit prescale select and the top three divisor bits. The transmit and receive sides each pick their 16x source on their own: either the internal chain, or rising edges seen on an external clock pin after synchronisation. A select value of zero is the power-down state. In that state every counter is held cleared and no output pulses, whatever the external pin does.

Top module: `baud_tick_gen`

## Requirements
- R1: Out of reset both registers read as zero, so the block is powered down and none of the four enables pulses until a nonzero select is written.
- R2: While the select field is 0, tx_ovs_en, rx_ovs_en, tx_bit_en and rx_bit_en stay low, even when the external clock toggles.
- R3: A select value n from 1 to 31 divides by (n+1)/2. For odd n, prescaler pulses are spaced exactly (n+1)/2 cycles apart. For even n, the spacings alternate between n/2 and n/2+1 cycles, so any eight consecutive spacings sum to 4*(n+1).
- R4: With divisor D, a 16x enable is produced on every (D+1)-th prescaler pulse. The first one comes on the first prescaler pulse after power-down ends.
- R5: A write with wr_addr=0 loads divisor bits 7:0 from wr_data. A write with wr_addr=1 loads the select from wr_data[7:3] and divisor bits 10:8 from wr_data[2:0].
- R6: Each direction's bit enable pulses together with every 16th 16x enable of that direction, counted from power-down exit.
- R7: Each rising edge on ext_clk that is held for at least two cycles yields exactly one 16x enable on every direction that selects the external source, within four clock cycles.
- R8: tx_src_ext and rx_src_ext act independently: 1 selects the external pin, 0 the internal chain, for that direction only.
- R9: Every enable output is high for only one cycle at a time whenever its period exceeds one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0: low divisor byte, 1: select and high divisor bits |
| wr_data | input | 8 | Register write data |
| ext_clk | input | 1 | Asynchronous external 16x clock |
| tx_src_ext | input | 1 | Transmit side uses external clock when 1 |
| rx_src_ext | input | 1 | Receive side uses external clock when 1 |
| tx_ovs_en | output | 1 | Transmit 16x enable |
| rx_ovs_en | output | 1 | Receive 16x enable |
| tx_bit_en | output | 1 | Transmit bit-rate enable |
| rx_bit_en | output | 1 | Receive bit-rate enable |

## Verification
The assertions check on every cycle that power-down silences all outputs and that each enable is a single-cycle pulse. They also check that prescaler pulses and 16x enables are never adjacent when the configured period forbids it, and that a bit enable only comes with a source enable. Only the bench's scenarios can show the exact periods. These are the half-step alternation across all 31 select values, the divisor split over both registers, the divide-by-16 count, and the one-for-one mapping of external edges with independent per-direction selection.

// File: rtl/bg_pkg.sv
package bg_pkg;
  // Prescaler period for select sel in the given half-step phase.
  // Odd sel: fixed (sel+1)/2. Even sel: sel/2 then sel/2+1, alternating.
  function automatic int pre_len(input int sel, input logic long_phase);
    if (sel[0]) return (sel + 1) / 2;
    else        return sel / 2 + (long_phase ? 1 : 0);
  endfunction

  typedef enum logic {SRC_INTERNAL = 1'b0, SRC_EXTERNAL = 1'b1} clk_src_e;
endpackage

// File: rtl/bg_prescaler.sv
module bg_prescaler #(
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             pre_tick
);
  import bg_pkg::*;
  localparam int CNT_W = SEL_W;

  logic [CNT_W-1:0] cnt;
  logic             long_ph;
  logic             pwr_down;
  logic [CNT_W-1:0] period;

  assign pwr_down = (sel == '0);
  assign period   = CNT_W'(pre_len(int'(sel), long_ph));
  assign pre_tick = !pwr_down && (cnt == period - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_down) begin
      cnt     <= '0;
      long_ph <= 1'b0;
    end else if (pre_tick) begin
      cnt     <= '0;
      long_ph <= ~long_ph;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_PRE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_tick && sel >= SEL_W'(3)) |=> (!pre_tick || sel != $past(sel))); // R3
endmodule

// File: rtl/bg_divisor.sv
module bg_divisor #(
  parameter int DIV_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down,
  input  logic             pre_tick,
  input  logic [DIV_W-1:0] divisor,
  output logic             ovs_tick
);
  logic [DIV_W-1:0] cnt;

  assign ovs_tick = pre_tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_down) cnt <= '0;
    else if (pre_tick)      cnt <= (cnt == '0) ? divisor : cnt - 1'b1;
  end

  AST_OVS_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (ovs_tick && divisor != '0 && !pwr_down) |=> (!ovs_tick || $changed(divisor) || pwr_down)); // R4
endmodule

// File: rtl/bg_edge_sync.sv
module bg_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic meta, stab, prev;

  always_ff @(posedge clk) begin
    if (!rst_n) {meta, stab, prev} <= '0;
    else        {meta, stab, prev} <= {async_in, meta, stab};
  end

  assign rise = stab && !prev;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R7
endmodule

// File: rtl/bg_bit_div.sv
module bg_bit_div #(
  parameter int RATIO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down,
  input  logic src_en,
  output logic bit_en
);
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  logic [CW-1:0] cnt;

  assign bit_en = src_en && (cnt == CW'(RATIO - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_down) cnt <= '0;
    else if (src_en)        cnt <= bit_en ? '0 : cnt + 1'b1;
  end

  AST_BIT_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |-> !pwr_down); // R6
  AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> !bit_en); // R9
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int REG_W     = 8,
  parameter int DIV_W     = 11,
  parameter int OVS_RATIO = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             ext_clk,
  input  logic             tx_src_ext,
  input  logic             rx_src_ext,
  output logic             tx_ovs_en,
  output logic             rx_ovs_en,
  output logic             tx_bit_en,
  output logic             rx_bit_en
);
  import bg_pkg::*;
  localparam int HI_W  = DIV_W - REG_W;
  localparam int SEL_W = REG_W - HI_W;
  localparam int N_DIR = 2;

  logic [REG_W-1:0] div_lo_q;
  logic [REG_W-1:0] psel_q;
  logic [SEL_W-1:0] sel;
  logic [DIV_W-1:0] divisor;
  logic             pwr_down;
  logic             pre_tick, int_ovs, ext_rise;
  clk_src_e         src_sel [N_DIR];
  logic [N_DIR-1:0] ovs_v, bit_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_lo_q <= '0;
      psel_q   <= '0;
    end else if (wr_en) begin
      if (wr_addr) psel_q   <= wr_data;
      else         div_lo_q <= wr_data;
    end
  end

  assign sel      = psel_q[REG_W-1 -: SEL_W];
  assign divisor  = {psel_q[HI_W-1:0], div_lo_q};
  assign pwr_down = (sel == '0);

  bg_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(sel), .pre_tick(pre_tick));

  bg_divisor #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .pre_tick(pre_tick),
    .divisor(divisor), .ovs_tick(int_ovs));

  bg_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_clk), .rise(ext_rise));

  assign src_sel[0] = clk_src_e'(tx_src_ext);
  assign src_sel[1] = clk_src_e'(rx_src_ext);

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    assign ovs_v[d] = !pwr_down &&
                      ((src_sel[d] == SRC_EXTERNAL) ? ext_rise : int_ovs);
    bg_bit_div #(.RATIO(OVS_RATIO)) u_bit (
      .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
      .src_en(ovs_v[d]), .bit_en(bit_v[d]));
  end

  assign tx_ovs_en = ovs_v[0];
  assign rx_ovs_en = ovs_v[1];
  assign tx_bit_en = bit_v[0];
  assign rx_bit_en = bit_v[1];

  AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (psel_q[REG_W-1 -: SEL_W] == '0) |-> !(tx_ovs_en || rx_ovs_en || tx_bit_en || rx_bit_en)); // R2
  AST_BIT_WITH_OVS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bit_en |-> tx_ovs_en) and (rx_bit_en |-> rx_ovs_en)); // R6
  AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_src_ext && tx_ovs_en) |=> (!tx_ovs_en || !tx_src_ext)); // R9
endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic ext_clk = 1'b0, tx_src_ext = 1'b0, rx_src_ext = 1'b0;
  logic tx_ovs_en, rx_ovs_en, tx_bit_en, rx_bit_en;

  int errors = 0, checks = 0, cyc = 0;
  int cnt [4];
  int iv [16];

  always #5 clk = ~clk;

  baud_tick_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_clk(ext_clk), .tx_src_ext(tx_src_ext), .rx_src_ext(rx_src_ext),
    .tx_ovs_en(tx_ovs_en), .rx_ovs_en(rx_ovs_en),
    .tx_bit_en(tx_bit_en), .rx_bit_en(rx_bit_en));

  function automatic logic sig(input int w);
    case (w)
      0: return tx_ovs_en;
      1: return rx_ovs_en;
      2: return tx_bit_en;
      default: return rx_bit_en;
    endcase
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    for (int w = 0; w < 4; w++) if (sig(w)) cnt[w]++;
  endtask

  task automatic clear_cnt();
    for (int w = 0; w < 4; w++) cnt[w] = 0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Record n intervals between consecutive pulses on output w.
  task automatic collect(input int w, input int n, input string req);
    int c = 0, k = -1, guard = 0;
    while (k < n && guard < 40000) begin
      @(negedge clk);
      guard++; c++;
      if (sig(w)) begin
        if (k >= 0) iv[k] = c;
        k++; c = 0;
      end
    end
    if (k < n) begin
      check(1'b0, req, k, n);
      for (int i = 0; i < n; i++) iv[i] = 0;
    end
  endtask

  initial begin
    while (cyc < 200000) begin @(posedge clk); cyc++; end
    check(1'b0, "watchdog", cyc, 200000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state, nothing pulses with registers cleared
    clear_cnt();
    repeat (4) step();
    rst_n = 1'b1;
    repeat (60) step();
    check(cnt[0] + cnt[1] + cnt[2] + cnt[3] == 0, "R1", cnt[0] + cnt[1] + cnt[2] + cnt[3], 0);

    // R3: sweep all select values with divisor 0 (R5 low byte)
    wr(1'b0, 8'h00);
    for (int n = 1; n < 32; n++) begin
      int lo, hi, tot;
      logic ok, alt;
      wr(1'b1, 8'h00);
      wr(1'b1, 8'(n << 3));
      collect(0, 8, "R3");
      lo = n / 2 + (n % 2);
      hi = (n % 2) ? lo : lo + 1;
      if (n % 2 == 0) lo = n / 2;
      tot = 0; ok = 1'b1; alt = 1'b1;
      for (int i = 0; i < 8; i++) begin
        tot += iv[i];
        if (iv[i] != lo && iv[i] != hi) ok = 1'b0;
        if (i > 0 && (n % 2 == 0) && iv[i] == iv[i-1]) alt = 1'b0;
      end
      check(tot == 4 * (n + 1), "R3", tot, 4 * (n + 1));
      check(ok && alt, "R3", iv[0], lo);
    end

    // R4/R5: divisor spread over both registers, select 1 (divide by 1)
    for (int j = 0; j < 6; j++) begin
      int d;
      d = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 5 : (j == 3) ? 255 : (j == 4) ? 256 : 1537;
      wr(1'b1, 8'h00);
      wr(1'b0, 8'(d & 8'hFF));
      wr(1'b1, 8'(8'h08 | (d >> 8)));
      collect(1, 2, "R4");
      check(iv[0] == d + 1 && iv[1] == d + 1, "R4 R5", iv[0], d + 1);
    end

    // R4 with half-step prescale: select 4 (2.5), divisor 3 -> 2 periods = 20
    wr(1'b1, 8'h00);
    wr(1'b0, 8'd3);
    wr(1'b1, 8'(4 << 3));
    collect(0, 2, "R4");
    check(iv[0] + iv[1] == 20, "R4", iv[0] + iv[1], 20);

    // R6: bit enable every 16 x enables; select 1, divisor 2 -> 48 cycles
    wr(1'b1, 8'h00);
    wr(1'b0, 8'd2);
    wr(1'b1, 8'h08);
    collect(2, 2, "R6");
    check(iv[0] == 48 && iv[1] == 48, "R6", iv[0], 48);
    collect(3, 1, "R6");
    check(iv[0] == 48, "R6", iv[0], 48);

    // R7/R8: tx external, rx internal (divisor 9 -> every 10 cycles)
    wr(1'b1, 8'h00);
    wr(1'b0, 8'd9);
    tx_src_ext = 1'b1; rx_src_ext = 1'b0;
    wr(1'b1, 8'h08);
    clear_cnt();
    for (int e = 0; e < 20; e++) begin
      ext_clk = 1'b1; repeat (3) step();
      ext_clk = 1'b0; repeat (3) step();
    end
    repeat (6) step();
    check(cnt[0] == 20, "R7", cnt[0], 20);
    check(cnt[2] == 1, "R7", cnt[2], 1);
    check(cnt[1] >= 12 && cnt[1] <= 13, "R8", cnt[1], 12);

    // R8: swap roles
    tx_src_ext = 1'b0; rx_src_ext = 1'b1;
    clear_cnt();
    repeat (50) step();
    check(cnt[1] == 0, "R8", cnt[1], 0);
    check(cnt[0] >= 5, "R8", cnt[0], 5);

    // R2: power down with external clock toggling
    tx_src_ext = 1'b1;
    wr(1'b1, 8'h07);
    clear_cnt();
    for (int e = 0; e < 20; e++) begin
      ext_clk = 1'b1; repeat (3) step();
      ext_clk = 1'b0; repeat (3) step();
    end
    check(cnt[0] + cnt[1] + cnt[2] + cnt[3] == 0, "R2", cnt[0] + cnt[1] + cnt[2] + cnt[3], 0);

    // R9: single-cycle 16x pulses at select 4, divisor 0
    tx_src_ext = 1'b0; rx_src_ext = 1'b0;
    wr(1'b0, 8'd0);
    wr(1'b1, 8'(4 << 3));
    collect(0, 6, "R9");
    begin
      int mn = 99;
      for (int i = 0; i < 6; i++) if (iv[i] < mn) mn = iv[i];
      check(mn >= 2, "R9", mn, 2);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule